// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns the 20-bit address of each bus reference into active-low select lines for external devices. Four memory selects split one programmable memory window into equal quarters. Seven peripheral selects each cover a 128-byte block above a programmable 1 KB-aligned base. That base can lie in the 64 KB I/O space or in the 1 MB memory space. Configuration comes from a small register-write port. A select stays inactive until its range register has been written.

The address is taken on each clock where the address strobe is high. The selects change on that edge and hold their value until the next strobe. The two highest peripheral pins can be switched, one by one, to carry address bits 1 and 2 captured by the strobe. While another master owns the bus (hold acknowledge), every select is driven inactive, the pins keep being driven, and the captured address bits keep their value.

Two strap inputs are sampled while reset is held. If both straps are low on the last reset cycle, the pad enable drops and every output pin is released until the next reset.

Top module: `csel_decoder`

## Requirements
- R1: During reset and after it, `mcs_n` is 4'hF and `pcs_n` is 7'h7F, even for addresses in the default ranges, until the matching range register is written (memory window register for `mcs_n`, peripheral register for `pcs_n`).
- R2: Writing `cfg_sel`=0 sets the memory window. `cfg_wdata[6:0]` holds address bits 19:13 of the base, and `cfg_wdata[10:8]` holds the size code k (7 acts as 6). The window size is 8 KB << k, and base bits below the window size are ignored.
- R3: On a memory cycle inside the window, exactly one `mcs_n[q]` is low, where q is (address − window base) divided by a quarter of the window size. Outside the window, and on I/O cycles, all memory selects are high.
- R4: Writing `cfg_sel`=1 sets the peripheral area. `cfg_wdata[9:0]` holds base bits 19:10, and `cfg_wdata[15]` selects memory space (1) or I/O space (0). Selecting memory space makes `pcs_n[i]` low for memory cycles at base+128·i to base+128·i+127, for i = 0..6. Offsets 896..1023 and addresses outside the area select nothing.
- R5: In I/O space, peripheral selects respond only to I/O cycles, and address bits 19:16 and base bits 19:16 are ignored.
- R6: Writing `cfg_sel`=2 sets the latch modes. When bit 0 is set, `pcs_n[5]` shows address bit 1 captured at the last accepted strobe. When bit 1 is set, `pcs_n[6]` shows captured address bit 2.
- R7: Outputs update on the clock edge that samples `ale` high with `hlda` low. Without such a strobe, the selects keep their value even if the address, the cycle type or the range registers change.
- R8: On an edge that samples `hlda` high, all selects go high and the strobe is ignored. The captured address bits keep their value, and `pads_oe` stays high.
- R9: `pads_oe` goes low after a reset whose last cycle saw both `strap_a_n` and `strap_b_n` low, and it stays low until the next reset. If only one strap is low, `pads_oe` stays high. Strap changes outside reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; straps are sampled while it is high |
| strap_a_n | input | 1 | First test-mode strap, active low |
| strap_b_n | input | 1 | Second test-mode strap, active low |
| addr | input | 20 | Bus address |
| ale | input | 1 | Address strobe, high for one cycle per reference |
| mem_cyc | input | 1 | 1 = memory reference, 0 = I/O reference |
| hlda | input | 1 | Hold acknowledge; another master owns the bus |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select: 0 memory window, 1 peripheral area, 2 latch modes |
| cfg_wdata | input | 16 | Register write data |
| mcs_n | output | 4 | Memory-window quarter selects, active low |
| pcs_n | output | 7 | Peripheral selects, active low; bits 6 and 5 can carry latched A2/A1 |
| pads_oe | output | 1 | Output pad enable; low in the released-pin test mode |

## Verification
The hardest state to reach is a latched-address pin holding its value while hold is asserted and a strobe arrives with a different address. This needs the latch mode written, a strobe with known A1/A2, and then a second strobe presented under hold. The bench builds this sequence in a fixed order and checks that the pins keep the earlier bits. The window boundaries are swept for every size code, including the clamped code 7 and an unaligned base field.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int ADDR_W   = 20;
  localparam int CFG_W    = 16;
  localparam int N_MID    = 4;
  localparam int QB       = $clog2(N_MID);
  localparam int MID_LO   = 13;
  localparam int MB       = ADDR_W - MID_LO;
  localparam int MID_MAXC = ADDR_W - 1 - MID_LO;
  localparam int CODE_W   = $clog2(MID_MAXC + 1);
  localparam int N_PER    = 7;
  localparam int LAT_N    = 2;
  localparam int PER_BLK  = 7;
  localparam int PER_AL   = 10;
  localparam int IDX_W    = PER_AL - PER_BLK;
  localparam int IO_W     = 16;

  typedef struct packed {
    logic [MB-1:0]     base;
    logic [CODE_W-1:0] code;
  } mid_cfg_t;

  typedef struct packed {
    logic [ADDR_W-PER_AL-1:0] base;
    logic                     in_mem;
  } per_cfg_t;

  function automatic int mid_clamp(input logic [CODE_W-1:0] code);
    return (int'(code) > MID_MAXC) ? MID_MAXC : int'(code);
  endfunction

  function automatic logic mid_region(input logic [ADDR_W-1:0] a, input mid_cfg_t c);
    logic [MB-1:0] mask;
    mask = {MB{1'b1}} << mid_clamp(c.code);
    return ((a[ADDR_W-1:MID_LO] ^ c.base) & mask) == '0;
  endfunction

  function automatic logic [QB-1:0] mid_quarter(input logic [ADDR_W-1:0] a, input mid_cfg_t c);
    logic [ADDR_W-1:0] sh;
    sh = a >> (MID_LO - QB + mid_clamp(c.code));
    return sh[QB-1:0];
  endfunction

  function automatic logic per_match(input logic [ADDR_W-1:0] a, input logic is_mem,
                                     input per_cfg_t c);
    if (c.in_mem) return is_mem && (a[ADDR_W-1:PER_AL] == c.base);
    return !is_mem && (a[IO_W-1:PER_AL] == c.base[IO_W-PER_AL-1:0]);
  endfunction
endpackage

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
  import csel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [CFG_W-1:0] wdata,
  output mid_cfg_t         mid_cfg,
  output logic             mid_ok,
  output per_cfg_t         per_cfg,
  output logic             per_ok,
  output logic [LAT_N-1:0] lat_mode
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[CFG_W-2:11], wdata[7]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_cfg  <= '0;
      mid_ok   <= 1'b0;
      per_cfg  <= '0;
      per_ok   <= 1'b0;
      lat_mode <= '0;
    end else if (we) begin
      case (sel)
        2'd0: begin
          mid_cfg.base <= wdata[MB-1:0];
          mid_cfg.code <= wdata[8 +: CODE_W];
          mid_ok       <= 1'b1;
        end
        2'd1: begin
          per_cfg.base   <= wdata[ADDR_W-PER_AL-1:0];
          per_cfg.in_mem <= wdata[CFG_W-1];
          per_ok         <= 1'b1;
        end
        2'd2: lat_mode <= wdata[LAT_N-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csel_mid_dec.sv
module csel_mid_dec
  import csel_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_cyc,
  input  mid_cfg_t          cfg,
  input  logic              ok,
  output logic [N_MID-1:0]  hit
);
  logic          in_win;
  logic [QB-1:0] quarter;

  assign in_win  = ok && mem_cyc && mid_region(addr, cfg);
  assign quarter = mid_quarter(addr, cfg);

  for (genvar i = 0; i < N_MID; i++) begin : g_q
    assign hit[i] = in_win && (quarter == QB'(i));
  end
endmodule

// File: rtl/csel_per_dec.sv
module csel_per_dec
  import csel_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_cyc,
  input  per_cfg_t          cfg,
  input  logic              ok,
  output logic [N_PER-1:0]  hit
);
  logic             in_area;
  logic [IDX_W-1:0] idx;

  assign in_area = ok && per_match(addr, mem_cyc, cfg);
  assign idx     = addr[PER_AL-1:PER_BLK];

  for (genvar i = 0; i < N_PER; i++) begin : g_p
    assign hit[i] = in_area && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_a_n,
  input  logic              strap_b_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ale,
  input  logic              mem_cyc,
  input  logic              hlda,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [N_MID-1:0]  mcs_n,
  output logic [N_PER-1:0]  pcs_n,
  output logic              pads_oe
);
  localparam int PLAIN_N = N_PER - LAT_N;

  mid_cfg_t         mid_cfg;
  per_cfg_t         per_cfg;
  logic             mid_ok, per_ok;
  logic [LAT_N-1:0] lat_mode;
  logic [N_MID-1:0] mid_hit;
  logic [N_PER-1:0] per_hit;
  logic [N_MID-1:0] mcs_q;
  logic [N_PER-1:0] pcs_q;
  logic [LAT_N-1:0] lat_q;
  logic             test_mode;
  logic             strobe;
  logic             unused_a0;

  assign unused_a0 = addr[0];
  assign strobe    = ale && !hlda;

  csel_cfg_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .mid_cfg(mid_cfg), .mid_ok(mid_ok), .per_cfg(per_cfg), .per_ok(per_ok),
    .lat_mode(lat_mode)
  );

  csel_mid_dec u_mid (
    .addr(addr), .mem_cyc(mem_cyc), .cfg(mid_cfg), .ok(mid_ok), .hit(mid_hit)
  );

  csel_per_dec u_per (
    .addr(addr), .mem_cyc(mem_cyc), .cfg(per_cfg), .ok(per_ok), .hit(per_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcs_q     <= '1;
      pcs_q     <= '1;
      lat_q     <= '0;
      test_mode <= !strap_a_n && !strap_b_n;
    end else if (hlda) begin
      mcs_q <= '1;
      pcs_q <= '1;
    end else if (strobe) begin
      mcs_q <= ~mid_hit;
      pcs_q <= ~per_hit;
      lat_q <= addr[LAT_N:1];
    end
  end

  assign mcs_n   = mcs_q;
  assign pads_oe = !test_mode;
  assign pcs_n[PLAIN_N-1:0] = pcs_q[PLAIN_N-1:0];

  for (genvar g = 0; g < LAT_N; g++) begin : g_lat
    assign pcs_n[PLAIN_N+g] = lat_mode[g] ? lat_q[g] : pcs_q[PLAIN_N+g];
  end
endmodule

// File: rtl/csel_decoder_sva.sv
module csel_decoder_sva
  import csel_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ale,
  input logic             hlda,
  input logic [N_MID-1:0] mcs_n,
  input logic [N_PER-1:0] pcs_n,
  input logic             pads_oe,
  input logic             mid_ok,
  input logic [LAT_N-1:0] lat_q
);
  localparam int PLAIN_N = N_PER - LAT_N;

  a_r1_unwritten_idle: assert property (@(posedge clk) disable iff (rst)
    !mid_ok |-> &mcs_n);

  a_r3_one_quarter: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mcs_n));

  a_r4_one_periph: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~pcs_n[PLAIN_N-1:0]));

  a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    (!ale && !hlda) |=> ($stable(mcs_n) && $stable(pcs_n[PLAIN_N-1:0])));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    hlda |=> ((&mcs_n) && (&pcs_n[PLAIN_N-1:0]) && pads_oe));

  a_r8_latch_kept: assert property (@(posedge clk) disable iff (rst)
    hlda |=> $stable(lat_q));

  a_r9_oe_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(pads_oe));
endmodule

bind csel_decoder csel_decoder_sva u_sva (
  .clk(clk), .rst(rst), .ale(ale), .hlda(hlda), .mcs_n(mcs_n), .pcs_n(pcs_n),
  .pads_oe(pads_oe), .mid_ok(mid_ok), .lat_q(lat_q)
);

// File: tb/csel_decoder_test.sv
module csel_decoder_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        strap_a_n = 1, strap_b_n = 1;
  logic [19:0] addr = '0;
  logic        ale = 0, mem_cyc = 0, hlda = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  mcs_n;
  logic [6:0]  pcs_n;
  logic        pads_oe;

  int vecs = 0, errs = 0;
  bit m_w, p_w, p_mem;
  int m_field, m_code, p_field;
  bit [1:0] mode;
  bit la1, la2;

  always #10 clk = ~clk;

  csel_decoder uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit sa, input bit sb);
    @(negedge clk);
    rst = 1; strap_a_n = sa; strap_b_n = sb;
    repeat (3) @(negedge clk);
    rst = 0;
    m_w = 0; p_w = 0; mode = 0; la1 = 0; la2 = 0;
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel[1:0]; cfg_wdata = data[15:0];
    @(negedge clk);
    cfg_we = 0;
    if (sel == 0) begin m_w = 1; m_field = data & 'h7F; m_code = (data >> 8) & 7; end
    if (sel == 1) begin p_w = 1; p_field = data & 'h3FF; p_mem = data[15]; end
    if (sel == 2) mode = data[1:0];
  endtask

  task automatic apply(input int a, input bit mem);
    @(negedge clk);
    addr = a[19:0]; mem_cyc = mem; ale = 1;
    @(negedge clk);
    ale = 0;
    if (!hlda) begin la1 = a[1]; la2 = a[2]; end
  endtask

  function automatic int e_mcs(input int a, input bit mem);
    int k, size, base;
    logic [3:0] r = 4'hF;
    if (!m_w || !mem) return r;
    k = (m_code > 6) ? 6 : m_code;
    size = 8192 << k;
    base = (m_field << 13) & ~(size - 1);
    if (a >= base && a < base + size) r[(a - base) / (size / 4)] = 1'b0;
    return r;
  endfunction

  function automatic int e_pcs(input int a, input bit mem);
    logic [6:0] r = 7'h7F;
    int base, off;
    bit hit;
    if (p_w) begin
      base = p_field << 10;
      if (p_mem) begin off = a - base; hit = mem; end
      else begin off = (a % 65536) - (base % 65536); hit = !mem; end
      if (hit && off >= 0 && off < 896) r[off / 128] = 1'b0;
    end
    if (mode[0]) r[5] = la1;
    if (mode[1]) r[6] = la2;
    return r;
  endfunction

  task automatic vec(input string req, input int a, input bit mem);
    apply(a, mem);
    chk({req, " mcs"}, mcs_n, e_mcs(a, mem));
    chk({req, " pcs"}, pcs_n, e_pcs(a, mem));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int size, base, qs, k;
    do_reset(1, 1);
    // R1: reset state and unwritten registers
    chk("R1 mcs reset", mcs_n, 4'hF);
    chk("R1 pcs reset", pcs_n, 7'h7F);
    chk("R9 oe straps high", pads_oe, 1);
    vec("R1 unwritten", 0, 1);
    vec("R1 unwritten io", 0, 0);

    // R2/R3: window sweep over every size code, unaligned base field
    for (int c = 0; c < 8; c++) begin
      wr(0, (c << 8) | 'h55);
      k = (c > 6) ? 6 : c;
      size = 8192 << k;
      base = ('h55 << 13) & ~(size - 1);
      qs = size / 4;
      if (base > 0) vec("R2 below", base - 1, 1);
      for (int q = 0; q < 4; q++) begin
        vec("R3 q start", base + q * qs, 1);
        vec("R3 q end", base + q * qs + qs - 1, 1);
      end
      if (base + size < (1 << 20)) vec("R2 above", base + size, 1);
      vec("R3 io ignored", base, 0);
    end

    // R4: peripheral area in memory space
    wr(1, 'h8000 | 'h2A5);
    vec("R4 below", ('h2A5 << 10) - 1, 1);
    for (int j = 0; j < 18; j++) vec("R4 mem blk", ('h2A5 << 10) + j * 64, 1);
    vec("R4 io cycle", 'h2A5 << 10, 0);

    // R5: peripheral area in I/O space, upper nibbles differ
    wr(1, 'h3C7);
    vec("R5 below", 'h70000 | 'h1BFF, 0);
    for (int j = 0; j < 18; j++) vec("R5 io blk", 'h70000 | ('h1C00 + j * 64), 0);
    vec("R5 mem cycle", 'h71C00, 0 + 1);

    // R6: latched A1/A2 on the upper peripheral pins
    wr(2, 3);
    vec("R6 a1", 'h71C02, 0);
    vec("R6 a2", 'h71C04, 0);
    vec("R6 blk5", 'h71C00 + 5 * 128 + 6, 0);
    wr(2, 1);
    vec("R6 pcs6 plain", 'h71C00 + 6 * 128, 0);
    wr(2, 3);
    vec("R6 set a1a2", 'h00006, 1);

    // R7: no strobe, no change (address, type and registers move)
    wr(0, (2 << 8) | 'h10);
    vec("R7 hit", 'h20000, 1);
    @(negedge clk); addr = 'h50000; mem_cyc = 0;
    repeat (3) @(negedge clk);
    chk("R7 addr change", mcs_n, 4'b1110);
    wr(0, (2 << 8) | 'h40);
    chk("R7 reg change", mcs_n, 4'b1110);
    vec("R7 new reg", 'h80000 + 8192 * 2, 1);

    // R8: hold with a strobe at another address
    vec("R8 pre", 'h71C02, 0);
    @(negedge clk); hlda = 1; addr = 'h80004; mem_cyc = 1; ale = 1;
    @(negedge clk); ale = 0;
    chk("R8 mcs idle", mcs_n, 4'hF);
    chk("R8 pcs latched kept", pcs_n, {la2, la1, 5'h1F});
    chk("R8 oe", pads_oe, 1);
    @(negedge clk); hlda = 0;
    @(negedge clk);
    chk("R8 after release", mcs_n, 4'hF);
    vec("R8 resume", 'h80000, 1);

    // R9: test-mode straps
    do_reset(0, 1);
    chk("R9 one strap", pads_oe, 1);
    do_reset(1, 0);
    chk("R9 other strap", pads_oe, 1);
    do_reset(0, 0);
    chk("R9 both straps", pads_oe, 0);
    @(negedge clk); strap_a_n = 1; strap_b_n = 1;
    apply('h1234, 1);
    repeat (3) @(negedge clk);
    chk("R9 sticky", pads_oe, 0);
    do_reset(1, 1);
    chk("R9 cleared", pads_oe, 1);
    chk("R1 after reset", pcs_n, 7'h7F);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule